// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This block holds the write-protection state of every erase block in a flash array of `NUM_BLKS` blocks (71 by default). Each block is open, locked, or locked down. A command port sets a block to one of the three states. A request port asks whether a program or erase of a block may go ahead, and the answer comes back combinationally in the same cycle. A query port reads the state of any block without side effects.

Commands are registered. A request in the cycle after a command therefore already sees the new state. Every block starts out locked after reset.

A locked-down block cannot be relaxed by ordinary commands. Only a reset or an asserted override input can move it to another state. A refused request raises a one-cycle protection-error pulse that carries the block number. An index beyond the array raises an address-error pulse instead.

Top module: `blk_prot_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, every block reads as locked (2'b01). `prot_err`, `addr_err` and `err_blk` are 0.
- R2: `qry_state` returns, in the same cycle, the 2-bit state of block `qry_blk`: 2'b00 open, 2'b01 locked, 2'b11 locked down. An index of `NUM_BLKS` or more reads 2'b11.
- R3: `cmd_op` 2'b01 (lock) makes a block 2'b01 and 2'b10 (unlock) makes it 2'b00, provided the block is not locked down. 2'b00 is a no-op.
- R4: `cmd_op` 2'b11 (lock down) makes the target block 2'b11 from any state.
- R5: A locked-down block stays 2'b11 under lock and unlock commands while `lockdn_ovr` is low.
- R6: While `lockdn_ovr` is high, unlock moves a locked-down block to 2'b00 and lock moves it to 2'b01.
- R7: With `req_valid` high, `req_allow` is high exactly when the block is in range and open. Otherwise `req_deny` is high. Both are low when `req_valid` is low.
- R8: A command updates state at the clock edge that ends its cycle. A request in the same cycle sees the old state, and a request in the next cycle sees the new one.
- R9: A request refused because its in-range block is locked or locked down gives a `prot_err` pulse in the next cycle, with `err_blk` equal to the block index. Otherwise `err_blk` is 0.
- R10: A command or request with an index of `NUM_BLKS` or more changes no state and gives an `addr_err` pulse in the next cycle. Such a request is denied and raises no `prot_err`.
- R11: A command changes only the block it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 lock down |
| cmd_blk | input | IDX_W | Target block of the command |
| lockdn_ovr | input | 1 | Lets lock/unlock act on locked-down blocks |
| req_valid | input | 1 | Program/erase permission request |
| req_blk | input | IDX_W | Block targeted by the request |
| req_allow | output | 1 | Request granted (combinational) |
| req_deny | output | 1 | Request refused (combinational) |
| qry_blk | input | IDX_W | Block to read back |
| qry_state | output | 2 | State of the queried block |
| prot_err | output | 1 | One-cycle pulse after a protection refusal |
| err_blk | output | IDX_W | Block of the refused request during `prot_err` |
| addr_err | output | 1 | One-cycle pulse after an out-of-range index |

## Verification
Directed sequences walk one block through every transition, with and without the override. They separate the lock-down freeze from the override path, and they show that lock and unlock are not simply ignored. A request placed in the same cycle as a command, and another in the following cycle, tell the old state from the new and so expose any extra or missing latency. Random traffic aims commands and requests at a small cluster of indices, so each lands on a freshly changed block. It also sprinkles in indices past the array, which separates protection refusals from address errors and shows whether a command leaks into neighbouring blocks.

// File: rtl/blk_prot_pkg.sv
package blk_prot_pkg;
    localparam logic [1:0] ST_OPEN   = 2'b00;
    localparam logic [1:0] ST_LOCKED = 2'b01;
    localparam logic [1:0] ST_FROZEN = 2'b11;

    localparam logic [1:0] OP_NONE   = 2'b00;
    localparam logic [1:0] OP_LOCK   = 2'b01;
    localparam logic [1:0] OP_UNLOCK = 2'b10;
    localparam logic [1:0] OP_FREEZE = 2'b11;
endpackage

// File: rtl/blk_lock_slot.sv
module blk_lock_slot
    import blk_prot_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       hit,
    input  logic [1:0] op,
    input  logic       ovr,
    output logic [1:0] nxt
);
    logic frozen;

    always_comb begin
        frozen = (cur == ST_FROZEN) && !ovr;
        nxt    = cur;
        if (hit) begin
            case (op)
                OP_FREEZE: nxt = ST_FROZEN;
                OP_LOCK:   if (!frozen) nxt = ST_LOCKED;
                OP_UNLOCK: if (!frozen) nxt = ST_OPEN;
                default:   nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/blk_state_sel.sv
module blk_state_sel
    import blk_prot_pkg::*;
#(
    parameter int NUM_BLKS = 71,
    parameter int IDX_W    = $clog2(NUM_BLKS)
) (
    input  logic [NUM_BLKS-1:0][1:0] st,
    input  logic [IDX_W-1:0]         idx,
    output logic                     in_range,
    output logic [1:0]               state
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLKS - 1);

    always_comb begin
        in_range = (idx <= LAST_IDX);
        state    = ST_FROZEN;
        if (in_range) state = st[idx];
    end
endmodule

// File: rtl/blk_prot_ctrl.sv
module blk_prot_ctrl
    import blk_prot_pkg::*;
#(
    parameter int NUM_BLKS = 71,
    parameter int IDX_W    = $clog2(NUM_BLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_blk,
    input  logic             lockdn_ovr,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_blk,
    output logic             req_allow,
    output logic             req_deny,
    input  logic [IDX_W-1:0] qry_blk,
    output logic [1:0]       qry_state,
    output logic             prot_err,
    output logic [IDX_W-1:0] err_blk,
    output logic             addr_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLKS - 1);

    typedef struct packed {
        logic [NUM_BLKS-1:0][1:0] st;
        logic                     perr;
        logic [IDX_W-1:0]         eblk;
        logic                     aerr;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_BLKS-1:0][1:0] nxt_st;
    logic                     cmd_in;
    logic                     req_in;
    logic                     qry_in;
    logic [1:0]               req_st;

    assign cmd_in = (cmd_blk <= LAST_IDX);

    for (genvar i = 0; i < NUM_BLKS; i++) begin : g_slot
        blk_lock_slot u_slot (
            .cur (r_q.st[i]),
            .hit (cmd_valid && (cmd_blk == IDX_W'(i))),
            .op  (cmd_op),
            .ovr (lockdn_ovr),
            .nxt (nxt_st[i])
        );
    end

    blk_state_sel #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)) u_req_sel (
        .st       (r_q.st),
        .idx      (req_blk),
        .in_range (req_in),
        .state    (req_st)
    );

    blk_state_sel #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)) u_qry_sel (
        .st       (r_q.st),
        .idx      (qry_blk),
        .in_range (qry_in),
        .state    (qry_state)
    );

    always_comb begin
        req_allow = req_valid && req_in && (req_st == ST_OPEN);
        req_deny  = req_valid && !req_allow;

        r_d      = r_q;
        r_d.st   = nxt_st;
        r_d.perr = req_valid && req_in && (req_st != ST_OPEN);
        r_d.eblk = r_d.perr ? req_blk : '0;
        r_d.aerr = (cmd_valid && !cmd_in) || (req_valid && !req_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= {NUM_BLKS{ST_LOCKED}};
        end else begin
            r_q    <= r_d;
        end
    end

    assign prot_err = r_q.perr;
    assign err_blk  = r_q.eblk;
    assign addr_err = r_q.aerr;

    logic unused_qry_in;
    assign unused_qry_in = qry_in;
endmodule

// File: rtl/blk_prot_chk.sv
module blk_prot_chk #(
    parameter int NUM_BLKS = 71,
    parameter int IDX_W    = $clog2(NUM_BLKS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [1:0]               cmd_op,
    input logic [IDX_W-1:0]         cmd_blk,
    input logic                     lockdn_ovr,
    input logic                     req_valid,
    input logic [IDX_W-1:0]         req_blk,
    input logic                     req_allow,
    input logic                     req_deny,
    input logic                     prot_err,
    input logic [IDX_W-1:0]         err_blk,
    input logic                     addr_err,
    input logic [NUM_BLKS-1:0][1:0] st
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLKS - 1);

    assert_one_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_allow, req_deny}) && (req_valid == (req_allow || req_deny)));

    assert_closed_denied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_blk <= LAST_IDX && st[req_blk] != 2'b00) |-> req_deny);

    assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11 && cmd_blk <= LAST_IDX)
        |=> st[$past(cmd_blk)] == 2'b11);

    assert_frozen_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10) && !lockdn_ovr
         && cmd_blk <= LAST_IDX && st[cmd_blk] == 2'b11)
        |=> st[$past(cmd_blk)] == 2'b11);

    assert_ovr_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10 && lockdn_ovr && cmd_blk <= LAST_IDX)
        |=> st[$past(cmd_blk)] == 2'b00);

    assert_perr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_deny && req_blk <= LAST_IDX)
        |=> prot_err && err_blk == $past(req_blk));

    assert_cmd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_blk > LAST_IDX) |=> addr_err && $stable(st));
endmodule

bind blk_prot_ctrl blk_prot_chk #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_blk    (cmd_blk),
    .lockdn_ovr (lockdn_ovr),
    .req_valid  (req_valid),
    .req_blk    (req_blk),
    .req_allow  (req_allow),
    .req_deny   (req_deny),
    .prot_err   (prot_err),
    .err_blk    (err_blk),
    .addr_err   (addr_err),
    .st         (r_q.st)
);

// File: tb/blk_prot_ctrl_test.sv
`timescale 1ns/1ps
module blk_prot_ctrl_test;
    localparam int N  = 71;
    localparam int IW = $clog2(N);
    localparam int MAXIDX = (1 << IW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [IW-1:0] cmd_blk = '0;
    logic          lockdn_ovr = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_blk = '0;
    logic          req_allow, req_deny;
    logic [IW-1:0] qry_blk = '0;
    logic [1:0]    qry_state;
    logic          prot_err;
    logic [IW-1:0] err_blk;
    logic          addr_err;

    int n_chk  = 0;
    int n_fail = 0;
    int m [N];

    always #2.5 clk = ~clk;

    blk_prot_ctrl #(.NUM_BLKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .lockdn_ovr(lockdn_ovr), .req_valid(req_valid),
        .req_blk(req_blk), .req_allow(req_allow), .req_deny(req_deny),
        .qry_blk(qry_blk), .qry_state(qry_state), .prot_err(prot_err),
        .err_blk(err_blk), .addr_err(addr_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nxt_state(input int cur, input int op, input int ovr);
        if (op == 3) return 3;
        if (cur == 3 && ovr == 0) return cur;
        if (op == 1) return 1;
        if (op == 2) return 0;
        return cur;
    endfunction

    function automatic int q_exp(input int idx);
        return (idx < N) ? m[idx] : 3;
    endfunction

    // Called at a falling edge; ends at the next falling edge.
    task automatic step(input int cv, input int op, input int cb, input int ovr,
                        input int rv, input int rb, input int qb, input string qtag);
        int e_allow, e_deny, e_perr, e_eblk, e_aerr;
        cmd_valid  = cv[0];
        cmd_op     = op[1:0];
        cmd_blk    = IW'(cb);
        lockdn_ovr = ovr[0];
        req_valid  = rv[0];
        req_blk    = IW'(rb);
        qry_blk    = IW'(qb);
        #1;
        e_allow = (rv != 0 && rb < N && m[rb] == 0) ? 1 : 0;
        e_deny  = (rv != 0 && e_allow == 0) ? 1 : 0;
        e_perr  = (rv != 0 && rb < N && m[rb] != 0) ? 1 : 0;
        e_eblk  = (e_perr != 0) ? rb : 0;
        e_aerr  = ((cv != 0 && cb >= N) || (rv != 0 && rb >= N)) ? 1 : 0;
        chk("R7/R8 req_allow", int'(req_allow), e_allow);
        chk("R7/R10 req_deny", int'(req_deny), e_deny);
        chk(qtag, int'(qry_state), q_exp(qb));
        if (cv != 0 && cb < N) m[cb] = nxt_state(m[cb], op, ovr);
        @(posedge clk);
        #1;
        chk("R9 prot_err", int'(prot_err), e_perr);
        chk("R9 err_blk", int'(err_blk), e_eblk);
        chk("R10 addr_err", int'(addr_err), e_aerr);
        @(negedge clk);
    endtask

    task automatic query(input int qb, input string tag);
        step(0, 0, 0, 0, 0, 0, qb, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0; req_valid = 1'b0; lockdn_ovr = 1'b0;
        for (int i = 0; i < N; i++) m[i] = 1;
        #1;
        qry_blk = IW'(10);
        #1;
        chk("R1 locked during reset", int'(qry_state), 1);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 prot_err low", int'(prot_err), 0);
        chk("R1 addr_err low", int'(addr_err), 0);
        chk("R1 err_blk zero", int'(err_blk), 0);
        for (int i = 0; i < N; i++) begin
            qry_blk = IW'(i);
            #0.1;
            chk("R1 block locked after reset", int'(qry_state), 1);
        end
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad_5eed));
        do_reset();

        query(N, "R2 query past end");
        query(MAXIDX, "R2 query top index");
        query(0, "R2 query block 0");

        // Locked block refused, error pulse names it
        step(0, 0, 0, 0, 1, 5, 5, "R7 locked block 5");
        // Same-cycle unlock: request still sees locked
        step(1, 2, 5, 0, 1, 5, 5, "R8 old state visible");
        step(0, 0, 0, 0, 1, 5, 5, "R3 unlocked block 5");
        query(4, "R11 neighbour 4 untouched");
        query(6, "R11 neighbour 6 untouched");
        step(1, 0, 5, 0, 1, 5, 5, "R3 nop keeps state");
        step(1, 1, 5, 0, 1, 5, 5, "R8 lock not yet seen");
        query(5, "R3 relocked block 5");

        // Lock-down freeze and override
        step(1, 3, 5, 0, 0, 0, 5, "R4 before freeze");
        query(5, "R4 frozen block 5");
        step(1, 2, 5, 0, 1, 5, 5, "R5 unlock attempt");
        query(5, "R5 still frozen after unlock");
        step(1, 1, 5, 0, 0, 0, 5, "R5 lock attempt");
        query(5, "R5 still frozen after lock");
        step(1, 2, 5, 1, 0, 0, 5, "R6 override unlock");
        step(0, 0, 0, 0, 1, 5, 5, "R6 open after override");
        step(1, 3, 5, 1, 0, 0, 5, "R4 freeze from open");
        step(1, 1, 5, 1, 0, 0, 5, "R6 override lock");
        query(5, "R6 locked after override");
        step(1, 3, 70, 0, 0, 0, 70, "R4 freeze last block");
        query(70, "R4 last block frozen");

        // Out-of-range index
        step(1, 2, N, 0, 0, 0, 70, "R10 bad cmd ignored");
        query(70, "R10 last block unchanged");
        step(1, 2, MAXIDX, 1, 1, 100, 0, "R10 bad cmd and req");
        query(0, "R10 block 0 unchanged");

        // Random traffic on a small cluster plus out-of-range indices
        for (int k = 0; k < 4000; k++) begin
            int cv, op, cb, ov, rv, rb, qb;
            cv = ($urandom % 2 == 0) ? 1 : 0;
            op = int'($urandom % 4);
            cb = ($urandom % 10 == 0) ? N + int'($urandom % (MAXIDX - N + 1)) : int'($urandom % 8);
            ov = ($urandom % 5 == 0) ? 1 : 0;
            rv = ($urandom % 3 != 0) ? 1 : 0;
            rb = ($urandom % 12 == 0) ? N + int'($urandom % (MAXIDX - N + 1)) : int'($urandom % 8);
            qb = ($urandom % 4 == 0) ? int'($urandom % (MAXIDX + 1)) : int'($urandom % 8);
            step(cv, op, cb, ov, rv, rb, qb, "R2/R3/R4/R5/R6/R11 random query");
        end

        do_reset();
        query(3, "R1 locked after second reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule